// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block gathers 32 level-sensitive interrupt sources for a primary vectored controller. Every source has its own enable bit. Software never writes the enable vector directly. It writes ones to a set port to enable sources and ones to a clear port to disable them, so two handlers can never undo each other's bits through a read-modify-write. A source is acknowledged by clearing its enable. The source itself stays level-sensitive and keeps its line asserted until the device releases it.

Enabled, active sources appear in a status register. The lowest set bit in that register is the one to service first. Sources are routed in one of two ways. Normally a source is merged into a single cascade line that feeds a fixed input of the primary controller. Setting a source's bit in the route register moves it onto a direct output of the same number, and it then no longer contributes to the cascade. A typical setup routes source 20 and sources 22 to 31 directly, using the route value 0xFFD00000.

Writes take effect at the clock edge on which they are presented. Read data and all interrupt outputs are combinational functions of the registered state and the current source levels.

Top module: `sic_cascade_ctrl`

## Requirements
- R1: While reset is high, and at the first clock edge after it, the enable vector and the route vector are zero. Both interrupt outputs are therefore deasserted.
- R2: A write to offset 0x08 sets every enable bit that is 1 in the write data. Bits that are 0 in the write data keep their previous value.
- R3: A write to offset 0x0C clears every enable bit that is 1 in the write data. Writing 0xFFFFFFFF disables every source.
- R4: A read of offset 0x00 returns the bitwise AND of the current source levels and the enable vector.
- R5: A read of offset 0x04 returns the current source levels, without any mask.
- R6: A read of offset 0x08 or of offset 0x0C returns the current enable vector.
- R7: A write to offset 0x20 loads the route vector, and a read of offset 0x20 returns it. Bit i set means source i is routed to direct line i.
- R8: `cascade_irq` is high exactly when some source is active, enabled and not routed.
- R9: `direct_irq[i]` is high exactly when source i is active, enabled and routed.
- R10: Writes to offsets 0x00, 0x04 or any unmapped offset change no state. Reads of unmapped offsets return 0.
- R11: The outputs follow the source levels and do not latch them. An active source stays pending until its enable is cleared or its level drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | 32 | Level-sensitive interrupt sources |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| cascade_irq | output | 1 | Merged line to the primary controller |
| direct_irq | output | 32 | Per-source direct lines for routed sources |

## Verification
The bench drives the route value 0xFFD00000 and activates source 20 next to the unrouted source 21. A design that forgets to take routed sources out of the merge raises the cascade for source 20. A design that ignores the enable on routed sources raises a direct line for a masked source.

The bench writes zero to the set port and checks that nothing changes, which catches a design that loads the enable vector instead of ORing into it. It writes all ones to the clear port to make sure every bit drops. It writes to the read-only status and raw offsets, which catches decode aliasing. It holds a source high and acknowledges it by clearing its enable, so a design that latches pending bits would keep the cascade asserted.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int unsigned SRC_W  = 32;
    localparam int unsigned ADDR_W = 6;

    typedef logic [SRC_W-1:0]  src_vec_t;
    typedef logic [ADDR_W-1:0] reg_addr_t;

    typedef enum logic [ADDR_W-1:0] {
        OFS_STATUS = 6'h00,
        OFS_RAW    = 6'h04,
        OFS_EN_SET = 6'h08,
        OFS_EN_CLR = 6'h0C,
        OFS_ROUTE  = 6'h20
    } reg_ofs_e;

    typedef struct packed {
        src_vec_t enable;
        src_vec_t route;
    } ctl_state_t;

    typedef struct packed {
        logic     cascade;
        src_vec_t direct;
        src_vec_t pending;
    } irq_out_t;

    function automatic logic addr_is(reg_addr_t a, reg_ofs_e ofs);
        return a == reg_addr_t'(ofs);
    endfunction

    // Set bits first, then clear them, so a clear always overrides a set.
    function automatic src_vec_t next_enable(src_vec_t cur, logic set_hit,
                                             logic clr_hit, src_vec_t wd);
        src_vec_t set_mask;
        src_vec_t clr_mask;
        set_mask = set_hit ? wd : '0;
        clr_mask = clr_hit ? wd : '0;
        return (cur | set_mask) & ~clr_mask;
    endfunction

endpackage

// File: rtl/sic_ctl_regs.sv
module sic_ctl_regs
    import sic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  reg_addr_t  wr_addr,
    input  src_vec_t   wr_data,
    output ctl_state_t state_o
);

    ctl_state_t state_q;
    ctl_state_t state_d;
    logic       hit_set;
    logic       hit_clr;
    logic       hit_route;

    always_comb begin
        hit_set   = wr_en && addr_is(wr_addr, OFS_EN_SET);
        hit_clr   = wr_en && addr_is(wr_addr, OFS_EN_CLR);
        hit_route = wr_en && addr_is(wr_addr, OFS_ROUTE);
        state_d        = state_q;
        state_d.enable = next_enable(state_q.enable, hit_set, hit_clr, wr_data);
        if (hit_route) begin
            state_d.route = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (state_q.enable == '0 && state_q.route == '0));

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == reg_addr_t'(OFS_EN_SET))
        |=> ((state_q.enable & $past(wr_data)) == $past(wr_data)));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == reg_addr_t'(OFS_EN_CLR))
        |=> ((state_q.enable & $past(wr_data)) == '0));

    // R10
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == reg_addr_t'(OFS_EN_SET) ||
                    wr_addr == reg_addr_t'(OFS_EN_CLR)))
        |=> $stable(state_q.enable));

    // R7
    route_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == reg_addr_t'(OFS_ROUTE))
        |=> (state_q.route == $past(wr_data)));

endmodule

// File: rtl/sic_route.sv
module sic_route
    import sic_pkg::*;
(
    input  src_vec_t   src_i,
    input  ctl_state_t ctl_i,
    output irq_out_t   out_o
);

    src_vec_t pend_v;
    src_vec_t dir_v;
    src_vec_t merge_v;

    for (genvar i = 0; i < SRC_W; i++) begin : g_src
        logic live;
        assign live       = src_i[i] & ctl_i.enable[i];
        assign pend_v[i]  = live;
        assign dir_v[i]   = live & ctl_i.route[i];
        assign merge_v[i] = live & ~ctl_i.route[i];
    end

    always_comb begin
        out_o.pending = pend_v;
        out_o.direct  = dir_v;
        out_o.cascade = |merge_v;
    end

endmodule

// File: rtl/sic_read_mux.sv
module sic_read_mux
    import sic_pkg::*;
(
    input  reg_addr_t  rd_addr,
    input  src_vec_t   src_i,
    input  ctl_state_t ctl_i,
    input  src_vec_t   pending_i,
    output src_vec_t   rd_data
);

    always_comb begin
        rd_data = '0;
        if (addr_is(rd_addr, OFS_STATUS)) begin
            rd_data = pending_i;
        end else if (addr_is(rd_addr, OFS_RAW)) begin
            rd_data = src_i;
        end else if (addr_is(rd_addr, OFS_EN_SET) || addr_is(rd_addr, OFS_EN_CLR)) begin
            rd_data = ctl_i.enable;
        end else if (addr_is(rd_addr, OFS_ROUTE)) begin
            rd_data = ctl_i.route;
        end
    end

endmodule

// File: rtl/sic_cascade_ctrl.sv
module sic_cascade_ctrl
    import sic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] src_level,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        cascade_irq,
    output logic [31:0] direct_irq
);

    ctl_state_t ctl;
    irq_out_t   irq;

    sic_ctl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .state_o (ctl)
    );

    sic_route u_route (
        .src_i (src_level),
        .ctl_i (ctl),
        .out_o (irq)
    );

    sic_read_mux u_rmux (
        .rd_addr   (reg_addr),
        .src_i     (src_level),
        .ctl_i     (ctl),
        .pending_i (irq.pending),
        .rd_data   (reg_rdata)
    );

    assign cascade_irq = irq.cascade;
    assign direct_irq  = irq.direct;

    // R8
    cascade_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((src_level & ctl.enable) == '0) |-> !cascade_irq);

    // R9
    direct_routed_chk: assert property (@(posedge clk) disable iff (rst)
        ((direct_irq & ~ctl.route) == '0));

    // R9
    direct_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        ((direct_irq & ~ctl.enable) == '0));

endmodule

// File: tb/sic_cascade_ctrl_bench.sv
module sic_cascade_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_level = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cascade_irq;
    logic [31:0] direct_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_en = '0;
    logic [31:0] m_route = '0;
    bit done = 0;

    always #5 clk = ~clk;

    sic_cascade_ctrl u_sic_cascade_ctrl (
        .clk(clk), .rst(rst), .src_level(src_level), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cascade_irq(cascade_irq), .direct_irq(direct_irq)
    );

    function automatic logic exp_cascade(logic [31:0] s, logic [31:0] e, logic [31:0] r);
        return |(s & e & ~r);
    endfunction

    function automatic logic [31:0] exp_direct(logic [31:0] s, logic [31:0] e, logic [31:0] r);
        return s & e & r;
    endfunction

    task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic read_chk(string req, logic [5:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check_eq(req, $sformatf("read 0x%02h", a), reg_rdata, exp);
    endtask

    task automatic bus_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 6'h08) m_en = m_en | d;
        if (a == 6'h0C) m_en = m_en & ~d;
        if (a == 6'h20) m_route = d;
    endtask

    task automatic drive_src(logic [31:0] s);
        @(negedge clk);
        src_level = s;
        #1;
    endtask

    task automatic check_all();
        check_eq("R8", "cascade_irq", {31'b0, cascade_irq},
                 {31'b0, exp_cascade(src_level, m_en, m_route)});
        check_eq("R9", "direct_irq", direct_irq, exp_direct(src_level, m_en, m_route));
        read_chk("R4", 6'h00, src_level & m_en);
        read_chk("R5", 6'h04, src_level);
        read_chk("R6", 6'h08, m_en);
        read_chk("R6", 6'h0C, m_en);
        read_chk("R7", 6'h20, m_route);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC0_1D20));
        src_level = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state, every source active but nothing enabled
        check_eq("R1", "cascade after reset", {31'b0, cascade_irq}, 32'h0);
        check_eq("R1", "direct after reset", direct_irq, 32'h0);
        read_chk("R1", 6'h08, 32'h0);
        read_chk("R1", 6'h20, 32'h0);

        // R2: set ports OR in ones; zero bits leave others alone
        drive_src(32'h0000_0000);
        bus_write(6'h08, 32'h0000_00F0);
        read_chk("R2", 6'h08, 32'h0000_00F0);
        bus_write(6'h08, 32'h0000_0000);
        read_chk("R2", 6'h08, 32'h0000_00F0);
        bus_write(6'h08, 32'h8000_0001);
        read_chk("R2", 6'h0C, 32'h8000_00F1);

        // R3: clear port, then clear all
        bus_write(6'h0C, 32'h0000_0010);
        read_chk("R3", 6'h08, 32'h8000_00E1);
        bus_write(6'h0C, 32'hFFFF_FFFF);
        read_chk("R3", 6'h08, 32'h0);

        // R10: writes to read-only and unmapped offsets change nothing
        bus_write(6'h08, 32'h0000_0F00);
        @(negedge clk); reg_wr = 1; reg_addr = 6'h00; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk); reg_addr = 6'h04;
        @(negedge clk); reg_addr = 6'h10;
        @(negedge clk); reg_wr = 0;
        read_chk("R10", 6'h08, 32'h0000_0F00);
        read_chk("R10", 6'h20, 32'h0);
        read_chk("R10", 6'h10, 32'h0);
        read_chk("R10", 6'h24, 32'h0);

        // R9/R8: typical route mask, source 20 routed, 21 merged
        bus_write(6'h08, 32'hFFFF_FFFF);
        bus_write(6'h20, 32'hFFD0_0000);
        drive_src(32'h0010_0000);
        check_eq("R8", "routed src20 cascade", {31'b0, cascade_irq}, 32'h0);
        check_eq("R9", "routed src20 direct", direct_irq, 32'h0010_0000);
        drive_src(32'h0020_0000);
        check_eq("R8", "merged src21 cascade", {31'b0, cascade_irq}, 32'h1);
        check_eq("R9", "merged src21 direct", direct_irq, 32'h0);
        // R9: routed but disabled source stays quiet
        bus_write(6'h0C, 32'h8000_0000);
        drive_src(32'h8000_0000);
        check_eq("R9", "disabled routed src31", direct_irq, 32'h0);

        // R11: acknowledge by masking while level held
        bus_write(6'h20, 32'h0);
        drive_src(32'h0000_0004);
        check_eq("R11", "pending before ack", {31'b0, cascade_irq}, 32'h1);
        bus_write(6'h0C, 32'h0000_0004);
        check_eq("R11", "cascade after ack", {31'b0, cascade_irq}, 32'h0);
        bus_write(6'h08, 32'h0000_0004);
        check_eq("R11", "re-enable level still high", {31'b0, cascade_irq}, 32'h1);
        drive_src(32'h0);
        check_eq("R11", "level dropped", {31'b0, cascade_irq}, 32'h0);
        check_all();

        // Random mix of writes and source changes
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: bus_write(6'h08, $urandom());
                1: bus_write(6'h0C, $urandom() & $urandom());
                2: bus_write(6'h20, $urandom());
                3: bus_write(6'h04, $urandom());
                default: drive_src($urandom() & $urandom() & $urandom());
            endcase
            check_all();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule